// File: doc/BRIEF.md
# Buffered 16-bit Event Timer

A 16-bit up-counter driven through an 8-bit register bus. It can count system clock cycles or rising edges of an external clock pin. The external pin is either passed through a two-flop synchronizer or sampled by a single flop for lower latency. A power-of-two prescaler sits in front of the counter. A compare register and a compare mode field let a match restart the count from zero and send out a one-cycle event pulse. A sticky overflow flag drives the interrupt output.

Software on an 8-bit bus cannot move 16 bits in one access. A wide access mode solves this with a shared high-byte buffer. A read of the low byte captures the live high byte into the buffer, so a read of the high byte that follows returns a value that belongs with the low byte already read. A write of the high byte only fills the buffer, and the write of the low byte that follows commits all 16 bits in one cycle. With the wide mode off, each byte of the counter is read and written directly.

Top module: `tmr16_buf`

## Requirements
- R1: After reset every register is zero, and bus_rdata, irq_ovf and evt_match are 0.
- R2: The counter advances only while control bit 0 is 1. While the bit is 0, the counter and the prescaler phase keep their values.
- R3: Control bits [5:4] = n set the prescale ratio to 2^n (1, 2, 4 or 8 counting ticks per increment). With the system clock as source, the count advances once every 2^n cycles.
- R4: When control bit 1 is 1, the source is rising edges of ext_clk. With control bit 2 = 0, an edge sampled at clock edge k counts at edge k+2 (two-flop synchronizer). With control bit 2 = 1, it counts at edge k+1 (single sampling flop).
- R5: When control bit 7 is 1, a bus read (bus_rd) of address 1 (count low byte) copies the live high byte into the buffer, and address 2 (count high byte) then reads the buffer.
- R6: When control bit 7 is 1, a write to address 2 changes only the buffer and leaves the counter unchanged. The next write to address 1 loads {buffer, data} into the counter in one cycle.
- R7: When control bit 7 is 0, addresses 1 and 2 read and write the low and high counter bytes directly. A high-byte write keeps the low byte.
- R8: Any write that changes the counter restarts the prescaler phase. A buffered high-byte write leaves the prescaler phase untouched, so the increment period is not stretched.
- R9: An increment taken at 16'hFFFF sets flag bit 0 of address 6 and irq_ovf. Both stay set until address 6 is written with bit 0 = 0, and a new overflow in the same cycle wins over the clear.
- R10: When the mode register (address 5, bits [3:0]) holds 4'b1011, an increment taken while the count equals the compare value (addresses 3 and 4) loads 0 instead, and evt_match pulses for one cycle. Any other code leaves the count running past the compare value.
- R11: The compare restart of R10 works the same way when the counter runs from ext_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External count clock |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 3 | Register address: 0 control, 1/2 count low/high, 3/4 compare low/high, 5 mode, 6 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_ovf | output | 1 | Overflow interrupt, the sticky flag |
| evt_match | output | 1 | One-cycle compare-restart event |

## Verification
The bench goes after the points where the buffered access can tear. It reads the buffer several cycles after a low-byte read while the counter keeps moving, which catches a design that passes the live high byte through. It also holds a buffered high-byte write pending for several cycles, which catches a counter that changes early. A buffered high-byte write lands in the middle of a divide-by-8 phase: a design that resets or stalls the prescaler there shifts every later increment. The bench also runs a compare restart from the external clock in both synchronizer settings, lands an overflow clear on the same edge as a new overflow, and checks that a compare code other than 4'b1011 lets the count run on past the compare value.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
    localparam int ADDR_W = 3;
    localparam int MODE_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd6;

    localparam int CTL_EN    = 0;
    localparam int CTL_EXT   = 1;
    localparam int CTL_ASYNC = 2;
    localparam int CTL_PS_LO = 4;
    localparam int CTL_WIDE  = 7;

    localparam logic [MODE_W-1:0] MODE_RESTART = 4'b1011;
endpackage

// File: rtl/tmr16_clksel.sv
`timescale 1ns/1ps
module tmr16_clksel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic use_ext,
    input  logic bypass_sync,
    output logic tick
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } cs_t;

    cs_t st_q, st_d;
    logic sel;

    always_comb begin
        st_d      = st_q;
        sel       = bypass_sync ? st_q.sync[0] : st_q.sync[SYNC_STAGES-1];
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], ext_clk};
        st_d.prev = sel;
        tick      = use_ext ? (sel & ~st_q.prev) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: an edge detector never yields two ticks in a row
    p_ext_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && tick) |=> (!use_ext || !tick));
endmodule

// File: rtl/tmr16_prescale.sv
`timescale 1ns/1ps
module tmr16_prescale #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    output logic            step
);
    localparam int PRE_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } ps_t;

    ps_t st_q, st_d;
    logic [PRE_W-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = PRE_W'((1 << ps) - 1);
        step = 1'b0;
        if (clr) begin
            st_d.pre = '0;
        end else if (en && tick) begin
            if (st_q.pre >= lim) begin
                st_d.pre = '0;
                step     = 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: right after a restart at the largest ratio no increment may follow
    p_clr_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ps == '1) |=> (ps != '1 || !step));
    // R2: no increment while disabled
    p_no_step_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !step);
endmodule

// File: rtl/tmr16_core.sv
`timescale 1ns/1ps
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              step,
    output logic [DATA_W-1:0] ctrl,
    output logic              cnt_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_ovf,
    output logic              evt_match
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] hbuf;
        logic              ovf;
        logic              evt;
    } core_t;

    core_t st_q, st_d;
    logic wide, restart, hit, ovf_set;

    always_comb begin
        st_d    = st_q;
        wide    = st_q.ctrl[CTL_WIDE];
        restart = (st_q.mode == MODE_RESTART);
        hit     = (st_q.cnt == st_q.cmp);
        cnt_wr  = bus_wr && (bus_addr == A_CNT_LO || (bus_addr == A_CNT_HI && !wide));
        ovf_set = 1'b0;
        st_d.evt = 1'b0;

        if (bus_wr) begin
            case (bus_addr)
                A_CTRL:   st_d.ctrl = bus_wdata;
                A_CMP_LO: st_d.cmp[DATA_W-1:0] = bus_wdata;
                A_CMP_HI: st_d.cmp[CNT_W-1:DATA_W] = bus_wdata;
                A_MODE:   st_d.mode = bus_wdata[MODE_W-1:0];
                A_FLAGS:  st_d.ovf = st_q.ovf & bus_wdata[0];
                A_CNT_HI: begin
                    if (wide) st_d.hbuf = bus_wdata;
                    else      st_d.cnt[CNT_W-1:DATA_W] = bus_wdata;
                end
                A_CNT_LO: begin
                    if (wide) st_d.cnt = {st_q.hbuf, bus_wdata};
                    else      st_d.cnt[DATA_W-1:0] = bus_wdata;
                end
                default: ;
            endcase
        end

        if (bus_rd && bus_addr == A_CNT_LO && wide)
            st_d.hbuf = st_q.cnt[CNT_W-1:DATA_W];

        if (step && !cnt_wr) begin
            ovf_set = (st_q.cnt == '1);
            if (restart && hit) begin
                st_d.cnt = '0;
                st_d.evt = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.ovf = st_d.ovf | ovf_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = st_q.ctrl;
            A_CNT_LO: bus_rdata = st_q.cnt[DATA_W-1:0];
            A_CNT_HI: bus_rdata = wide ? st_q.hbuf : st_q.cnt[CNT_W-1:DATA_W];
            A_CMP_LO: bus_rdata = st_q.cmp[DATA_W-1:0];
            A_CMP_HI: bus_rdata = st_q.cmp[CNT_W-1:DATA_W];
            A_MODE:   bus_rdata = DATA_W'(st_q.mode);
            A_FLAGS:  bus_rdata = DATA_W'(st_q.ovf);
            default:  bus_rdata = '0;
        endcase
    end

    assign ctrl      = st_q.ctrl;
    assign irq_ovf   = st_q.ovf;
    assign evt_match = st_q.evt;

    // R9: the flag stays set unless software writes the flags register
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !(bus_wr && bus_addr == A_FLAGS)) |=> st_q.ovf);
    // R10: the event coincides with a zero count
    p_match_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> (st_q.cnt == '0));
    // R10: an event only follows the restart code
    p_evt_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> ($past(st_q.mode) == MODE_RESTART));
    // R7: a direct high-byte write keeps the low byte
    p_narrow_hi_keeps_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CNT_HI && !wide) |=> $stable(st_q.cnt[DATA_W-1:0]));
    // R2: a disabled timer holds its count
    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl[CTL_EN] && !cnt_wr) |=> $stable(st_q.cnt));
endmodule

// File: rtl/tmr16_buf.sv
`timescale 1ns/1ps
module tmr16_buf
    import tmr16_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PS_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_ovf,
    output logic              evt_match
);
    logic [DATA_W-1:0] ctrl;
    logic              tick, step, cnt_wr;

    tmr16_clksel #(.SYNC_STAGES(SYNC_STAGES)) u_clksel (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk     (ext_clk),
        .use_ext     (ctrl[CTL_EXT]),
        .bypass_sync (ctrl[CTL_ASYNC]),
        .tick        (tick)
    );

    tmr16_prescale #(.PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl[CTL_EN]),
        .tick  (tick),
        .clr   (cnt_wr),
        .ps    (ctrl[CTL_PS_LO +: PS_W]),
        .step  (step)
    );

    tmr16_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .step      (step),
        .ctrl      (ctrl),
        .cnt_wr    (cnt_wr),
        .bus_rdata (bus_rdata),
        .irq_ovf   (irq_ovf),
        .evt_match (evt_match)
    );
endmodule

// File: tb/sim_tmr16_buf.sv
`timescale 1ns/1ps
module sim_tmr16_buf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd1;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_ovf, evt_match;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    tmr16_buf u0 (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ovf(irq_ovf), .evt_match(evt_match)
    );

    // behavioural reference
    int  m_ctrl, m_mode, m_cmp, m_cnt, m_hbuf, m_pre;
    bit  m_ovf, m_evt;
    int  hist[3];

    always @(posedge clk) begin
        bit wide, tick, wr_cnt, stp;
        int ratio, n_cnt, n_hbuf, n_ctrl, n_mode, n_cmp;
        bit n_ovf;
        if (!rst_n) begin
            m_ctrl = 0; m_mode = 0; m_cmp = 0; m_cnt = 0; m_hbuf = 0;
            m_pre = 0; m_ovf = 0; m_evt = 0;
            hist[0] = 0; hist[1] = 0; hist[2] = 0;
        end else begin
            wide = m_ctrl[7];
            if (!m_ctrl[1])     tick = 1;
            else if (m_ctrl[2]) tick = (hist[0] == 1) && (hist[1] == 0);
            else                tick = (hist[1] == 1) && (hist[2] == 0);
            wr_cnt = bus_wr && (bus_addr == 1 || (bus_addr == 2 && !wide));
            ratio = 1 << ((m_ctrl >> 4) & 3);
            stp = 0;
            if (wr_cnt) m_pre = 0;
            else if (m_ctrl[0] && tick) begin
                m_pre = m_pre + 1;
                if (m_pre >= ratio) begin m_pre = 0; stp = 1; end
            end
            n_cnt = m_cnt; n_hbuf = m_hbuf; n_ctrl = m_ctrl; n_mode = m_mode;
            n_cmp = m_cmp; n_ovf = m_ovf;
            if (bus_wr) begin
                case (bus_addr)
                    0: n_ctrl = bus_wdata;
                    1: n_cnt = wide ? (m_hbuf * 256 + bus_wdata) : ((m_cnt & 16'hFF00) | bus_wdata);
                    2: if (wide) n_hbuf = bus_wdata; else n_cnt = (m_cnt & 255) | (bus_wdata * 256);
                    3: n_cmp = (m_cmp & 16'hFF00) | bus_wdata;
                    4: n_cmp = (m_cmp & 255) | (bus_wdata * 256);
                    5: n_mode = bus_wdata & 15;
                    6: n_ovf = m_ovf && bus_wdata[0];
                    default: ;
                endcase
            end
            if (bus_rd && bus_addr == 1 && wide) n_hbuf = m_cnt / 256;
            m_evt = 0;
            if (stp) begin
                if (m_cnt == 65535) n_ovf = 1;
                if (m_mode == 11 && m_cnt == m_cmp) begin n_cnt = 0; m_evt = 1; end
                else n_cnt = (m_cnt + 1) % 65536;
            end
            m_cnt = n_cnt; m_hbuf = n_hbuf; m_ctrl = n_ctrl; m_mode = n_mode;
            m_cmp = n_cmp; m_ovf = n_ovf;
            hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = ext_clk;
        end
    end

    function automatic int exp_rdata(int a);
        case (a)
            0: return m_ctrl;
            1: return m_cnt % 256;
            2: return m_ctrl[7] ? m_hbuf : m_cnt / 256;
            3: return m_cmp % 256;
            4: return m_cmp / 256;
            5: return m_mode;
            6: return int'(m_ovf);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int er;
        #1;
        if (!done) begin
            er = exp_rdata(int'(bus_addr));
            vectors++;
            if (int'(bus_rdata) != er || irq_ovf != m_ovf || evt_match != m_evt) begin
                miscompares++;
                $display("FAIL %s: addr=%0d rdata=%02h irq=%0b evt=%0b, expected rdata=%02h irq=%0b evt=%0b",
                         cur_req, bus_addr, bus_rdata, irq_ovf, evt_match, er[7:0], m_ovf, m_evt);
            end
        end
    end

    task automatic cyc(bit w, bit r, logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(int n, logic [2:0] a = 3'd1);
        for (int i = 0; i < n; i++) cyc(0, 0, a, 8'h00);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        cyc(1, 0, a, d);
    endtask

    task automatic ext_run(int n, int period);
        for (int i = 0; i < n; i++) begin
            cyc(0, 0, 3'd1, 8'h00);
            ext_clk = (i % period) < (period / 2);
        end
        ext_clk = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        for (int a = 0; a < 8; a++) cyc(0, 0, 3'(a), 8'h00);
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 8; a++) cyc(0, 0, 3'(a), 8'h00);

        cur_req = "R2";
        wr(0, 8'h01); idle(20);
        wr(0, 8'h00); idle(10);
        wr(0, 8'h01); idle(10);

        cur_req = "R3";
        wr(0, 8'h11); idle(30);
        wr(0, 8'h21); idle(40);
        wr(0, 8'h31); idle(50);
        wr(0, 8'h30); idle(12);
        wr(0, 8'h31); idle(20);

        cur_req = "R4";
        wr(0, 8'h03); ext_run(60, 6);
        wr(0, 8'h07); ext_run(60, 4);
        wr(0, 8'h17); ext_run(40, 2);

        cur_req = "R5";
        wr(0, 8'h81); idle(5);
        cyc(0, 1, 3'd1, 8'h00);
        idle(12, 3'd2);
        wr(1, 8'hF0); idle(3);
        for (int k = 0; k < 8; k++) begin
            cyc(0, 1, 3'd1, 8'h00);
            idle(20, 3'd2);
        end

        cur_req = "R6";
        wr(2, 8'h12); idle(6); idle(4, 3'd2);
        wr(1, 8'h34); idle(8);
        wr(2, 8'hAB); wr(1, 8'hCD); idle(6);

        cur_req = "R7";
        wr(0, 8'h01);
        wr(2, 8'h5A); idle(4, 3'd2);
        wr(1, 8'h07); idle(4);
        idle(4, 3'd2);

        cur_req = "R8";
        wr(0, 8'hB1); idle(3);
        wr(2, 8'h40); idle(2);
        wr(2, 8'h41); idle(13);
        wr(1, 8'h00); idle(3);
        wr(1, 8'h10); idle(20);
        wr(0, 8'h31); idle(5); wr(1, 8'h22); idle(18);

        cur_req = "R9";
        wr(0, 8'h01);
        wr(2, 8'hFF); wr(1, 8'hF0); idle(20, 3'd6);
        wr(6, 8'h01); idle(4, 3'd6);
        wr(6, 8'h00); idle(4, 3'd6);
        wr(2, 8'hFF); wr(1, 8'hFD); idle(1, 3'd6);
        wr(6, 8'h00); idle(5, 3'd6);
        wr(6, 8'h00); idle(3, 3'd6);

        cur_req = "R10";
        wr(3, 8'h05); wr(4, 8'h00); wr(5, 8'h0B);
        wr(2, 8'h00); wr(1, 8'h00); idle(30);
        wr(5, 8'h0A); wr(1, 8'h00); idle(20);
        wr(5, 8'h0B); wr(3, 8'h00); wr(1, 8'h00); idle(8);
        wr(0, 8'h21); wr(3, 8'h03); wr(1, 8'h00); idle(40);
        for (int a = 3; a < 6; a++) cyc(0, 0, 3'(a), 8'h00);

        cur_req = "R11";
        wr(0, 8'h03); wr(1, 8'h00); ext_run(80, 4);
        wr(0, 8'h07); wr(1, 8'h00); ext_run(60, 4);

        idle(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule